// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block is the control state machine for the transmit side of a descriptor-driven DMA engine. Once started, it asks for a transmit descriptor. If the host has handed that descriptor to the DMA, the block requests that the frame be copied from host memory into the transmit FIFO. It then waits until the MAC reports that the frame has gone out, and requests that the descriptor be written back. After that it goes on to the next descriptor. The memory master, the FIFO storage and the MAC sit outside the block. Each of them is reached through a level request and a one-cycle completion input.

The current phase is always visible as a fixed 3-bit code. The codes are not sequential, and two of the eight values are never used. A descriptor that the host still owns parks the sequencer in a suspended phase until software issues a new start (poll). A stop request does not abort a frame in flight. The block completes the descriptor close and only then halts. Three one-cycle event outputs report these conditions to an interrupt block: frame closed, descriptor unavailable, and process halted. The phase code itself raises no event.

Top module: `tx_desc_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `state_code` is 000, all three request outputs are low and all three event outputs are low.
- R2: `state_code` takes only these values: 000 halted, 001 descriptor fetch, 011 data read into the FIFO, 010 waiting for end of transmission, 111 descriptor close, 110 suspended. The values 100 and 101 never appear.
- R3: In 000, a cycle with `cmd_start` high and `cmd_stop` low gives 001 in the next cycle. `cmd_start` has no effect in 001, 011, 010 or 111.
- R4: The normal order is 001 → 011 → 010 → 111 → 001. Fetch to read needs `fetch_ack` with `desc_own` high. Read to wait needs `rd_done`. Wait to close needs `tx_end`. Close to fetch needs `close_ack`. Each step is taken in the cycle after its input is sampled.
- R5: `fetch_req` is high exactly while the code is 001, `rd_req` exactly while it is 011, and `close_req` exactly while it is 111.
- R6: `evt_tx_done` is high for exactly one cycle: the first cycle after a `close_ack` sampled in 111.
- R7: `fetch_ack` with `desc_own` low in 001, with no stop pending, moves the code to 110. `evt_buf_unavail` is high for that one cycle.
- R8: In 110, `cmd_start` with `cmd_stop` low moves the code to 001 in the next cycle.
- R9: A `cmd_stop` seen in 001, 011, 010 or 111 is remembered. The frame still runs through its close. The `close_ack` that ends it then leads to 000, with `evt_stopped` and `evt_tx_done` both high in that cycle.
- R10: `cmd_stop` in 110 leads to 000 in the next cycle with an `evt_stopped` pulse. A stop pending when a fetch returns a descriptor not owned by the DMA leads to 000 with `evt_stopped` and no `evt_buf_unavail`.
- R11: In 000, `cmd_stop` raises no event. `cmd_start` together with `cmd_stop` leaves the code at 000.
- R12: A handshake input sampled outside the phase that uses it (`fetch_ack` outside 001, `rd_done` outside 011, `tx_end` outside 010, `close_ack` outside 111) changes neither the code nor any event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start or poll command, one cycle |
| cmd_stop | input | 1 | Stop command, one cycle |
| fetch_ack | input | 1 | Descriptor fetch complete |
| desc_own | input | 1 | Fetched descriptor is owned by the DMA (valid with fetch_ack) |
| rd_done | input | 1 | Frame data copied into the transmit FIFO |
| tx_end | input | 1 | MAC finished sending the frame |
| close_ack | input | 1 | Descriptor write-back complete |
| state_code | output | 3 | Current phase code |
| fetch_req | output | 1 | Descriptor fetch request |
| rd_req | output | 1 | Frame data read request |
| close_req | output | 1 | Descriptor write-back request |
| evt_tx_done | output | 1 | Frame closed pulse |
| evt_buf_unavail | output | 1 | Descriptor not available pulse |
| evt_stopped | output | 1 | Process halted pulse |

## Verification
The bench targets stops issued at awkward moments. A stop during data read or during the wait must not cut the frame short. A design that halted at once would show 000 before any close. A stop pending when an unowned descriptor comes back must halt the block rather than suspend it, and a design that got this wrong would raise the unavailable pulse. The bench also fires handshakes in the wrong phase and issues start and stop together. A design that decoded handshakes loosely would skip phases, and one with the wrong priority would leave the halted state.

// File: rtl/tx_seq_pkg.sv
// Shared types for the transmit descriptor sequencer.
// Assumes: phase codes are fixed by the software-visible encoding.
package tx_seq_pkg;
    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_HALT    = 3'b000,
        ST_FETCH   = 3'b001,
        ST_WAITEND = 3'b010,
        ST_READ    = 3'b011,
        ST_SUSP    = 3'b110,
        ST_CLOSE   = 3'b111
    } txst_e;

    typedef struct packed {
        logic done;
        logic unavail;
        logic halted;
    } txev_t;

    localparam int EV_W = $bits(txev_t);

    // True for the phases in which a stop is deferred to the close.
    function automatic logic is_active(input txst_e s);
        return (s == ST_FETCH) || (s == ST_READ) ||
               (s == ST_WAITEND) || (s == ST_CLOSE);
    endfunction
endpackage

// File: rtl/tx_seq_stop_track.sv
// Remembers a stop command seen while a descriptor is being processed.
// Assumes: cleared exactly when the sequencer enters the halted phase.
module tx_seq_stop_track
    import tx_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_stop,
    input  txst_e cur,
    input  txst_e nxt,
    output logic  stop_eff
);
    logic pend_q;

    // Effective stop: remembered one or one arriving this cycle.
    always_comb begin
        stop_eff = pend_q | (cmd_stop & is_active(cur));
    end

    // Hold the pending stop until the halted phase is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= stop_eff & (nxt != ST_HALT);
        end
    end
endmodule

// File: rtl/tx_seq_next.sv
// Next-phase and event decode for the transmit sequencer.
// Assumes: handshake inputs are single-cycle and only honoured in their own phase.
module tx_seq_next
    import tx_seq_pkg::*;
(
    input  txst_e cur,
    input  logic  cmd_start,
    input  logic  cmd_stop,
    input  logic  stop_eff,
    input  logic  fetch_ack,
    input  logic  desc_own,
    input  logic  rd_done,
    input  logic  tx_end,
    input  logic  close_ack,
    output txst_e nxt,
    output txev_t ev
);
    // Select the following phase and the events that accompany it.
    always_comb begin
        nxt = cur;
        ev  = '0;
        unique case (cur)
            ST_HALT: begin
                if (cmd_start && !cmd_stop) nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (fetch_ack) begin
                    if (desc_own) begin
                        nxt = ST_READ;
                    end else if (stop_eff) begin
                        nxt       = ST_HALT;
                        ev.halted = 1'b1;
                    end else begin
                        nxt        = ST_SUSP;
                        ev.unavail = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (rd_done) nxt = ST_WAITEND;
            end
            ST_WAITEND: begin
                if (tx_end) nxt = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (close_ack) begin
                    ev.done = 1'b1;
                    if (stop_eff) begin
                        nxt       = ST_HALT;
                        ev.halted = 1'b1;
                    end else begin
                        nxt = ST_FETCH;
                    end
                end
            end
            ST_SUSP: begin
                if (cmd_stop) begin
                    nxt       = ST_HALT;
                    ev.halted = 1'b1;
                end else if (cmd_start) begin
                    nxt = ST_FETCH;
                end
            end
            default: begin
                nxt = ST_HALT;
            end
        endcase
    end
endmodule

// File: rtl/tx_seq_out.sv
// Phase register, event pulse registers and request decode.
// Assumes: events are registered so that they line up with the new phase code.
module tx_seq_out
    import tx_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  txst_e           nxt,
    input  txev_t           ev,
    output txst_e           cur,
    output logic [ST_W-1:0] state_code,
    output logic            fetch_req,
    output logic            rd_req,
    output logic            close_req,
    output logic [EV_W-1:0] ev_q
);
    txst_e st_q;
    txev_t ev_r;

    // Register the phase and the one-cycle event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HALT;
            ev_r <= '0;
        end else begin
            st_q <= nxt;
            ev_r <= ev;
        end
    end

    // Decode the phase into the code and the level requests.
    always_comb begin
        cur        = st_q;
        state_code = st_q;
        fetch_req  = (st_q == ST_FETCH);
        rd_req     = (st_q == ST_READ);
        close_req  = (st_q == ST_CLOSE);
        ev_q       = ev_r;
    end
endmodule

// File: rtl/tx_desc_seq.sv
// Top of the transmit descriptor sequencer: wires the stop tracker, the
// next-phase decode and the output registers together.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module tx_desc_seq
    import tx_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic            cmd_stop,
    input  logic            fetch_ack,
    input  logic            desc_own,
    input  logic            rd_done,
    input  logic            tx_end,
    input  logic            close_ack,
    output logic [ST_W-1:0] state_code,
    output logic            fetch_req,
    output logic            rd_req,
    output logic            close_req,
    output logic            evt_tx_done,
    output logic            evt_buf_unavail,
    output logic            evt_stopped
);
    txst_e           cur;
    txst_e           nxt;
    txev_t           ev;
    logic            stop_eff;
    logic [EV_W-1:0] ev_q;
    txev_t           ev_o;

    tx_seq_stop_track u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_stop (cmd_stop),
        .cur      (cur),
        .nxt      (nxt),
        .stop_eff (stop_eff)
    );

    tx_seq_next u_next (
        .cur       (cur),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .stop_eff  (stop_eff),
        .fetch_ack (fetch_ack),
        .desc_own  (desc_own),
        .rd_done   (rd_done),
        .tx_end    (tx_end),
        .close_ack (close_ack),
        .nxt       (nxt),
        .ev        (ev)
    );

    tx_seq_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt        (nxt),
        .ev         (ev),
        .cur        (cur),
        .state_code (state_code),
        .fetch_req  (fetch_req),
        .rd_req     (rd_req),
        .close_req  (close_req),
        .ev_q       (ev_q)
    );

    // Unpack the registered events onto the named outputs.
    always_comb begin
        ev_o            = txev_t'(ev_q);
        evt_tx_done     = ev_o.done;
        evt_buf_unavail = ev_o.unavail;
        evt_stopped     = ev_o.halted;
    end
endmodule

// File: rtl/tx_desc_seq_chk.sv
// Property checker for tx_desc_seq, attached with bind.
// Assumes: observes only the ports of the top module.
module tx_desc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       fetch_ack,
    input logic       desc_own,
    input logic       rd_done,
    input logic       close_ack,
    input logic [2:0] state_code,
    input logic       fetch_req,
    input logic       rd_req,
    input logic       close_req,
    input logic       evt_tx_done,
    input logic       evt_buf_unavail,
    input logic       evt_stopped
);
    a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 3'b100) && (state_code != 3'b101));

    a_r5_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_req, rd_req, close_req}));

    a_r4_owned_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'b001 && fetch_ack && desc_own) |=> (state_code == 3'b011));

    a_r6_done_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_done |-> ($past(state_code) == 3'b111 && $past(close_ack)));

    a_r7_unavail_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf_unavail |-> (state_code == 3'b110 && !evt_tx_done));

    a_r9_stopped_is_halted: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stopped |-> (state_code == 3'b000));

    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'b000 && !cmd_start) |=> (state_code == 3'b000));

    a_r12_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'b011 && !rd_done) |=> (state_code == 3'b011));
endmodule

bind tx_desc_seq tx_desc_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_start       (cmd_start),
    .fetch_ack       (fetch_ack),
    .desc_own        (desc_own),
    .rd_done         (rd_done),
    .close_ack       (close_ack),
    .state_code      (state_code),
    .fetch_req       (fetch_req),
    .rd_req          (rd_req),
    .close_req       (close_req),
    .evt_tx_done     (evt_tx_done),
    .evt_buf_unavail (evt_buf_unavail),
    .evt_stopped     (evt_stopped)
);

// File: tb/tb_tx_desc_seq.sv
`timescale 1ns/1ps
module tb_tx_desc_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0, cmd_stop = 1'b0, fetch_ack = 1'b0, desc_own = 1'b0;
    logic       rd_done = 1'b0, tx_end = 1'b0, close_ack = 1'b0;
    logic [2:0] state_code;
    logic       fetch_req, rd_req, close_req;
    logic       evt_tx_done, evt_buf_unavail, evt_stopped;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";

    // Reference model state
    int m_st = 0;
    bit m_pend = 0, m_done = 0, m_un = 0, m_halt = 0;
    int ns;
    bit se, act;

    always #2 clk = ~clk;

    tx_desc_seq dut (.*);

    // Behavioural reference: phase codes as integers.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_done = 0; m_un = 0; m_halt = 0;
        end else begin
            ns = m_st; m_done = 0; m_un = 0; m_halt = 0;
            act = (m_st == 1 || m_st == 3 || m_st == 2 || m_st == 7);
            se = m_pend || (cmd_stop && act);
            if (m_st == 0) begin
                if (cmd_start && !cmd_stop) ns = 1;
            end else if (m_st == 1) begin
                if (fetch_ack) begin
                    if (desc_own) ns = 3;
                    else if (se) begin ns = 0; m_halt = 1; end
                    else begin ns = 6; m_un = 1; end
                end
            end else if (m_st == 3) begin
                if (rd_done) ns = 2;
            end else if (m_st == 2) begin
                if (tx_end) ns = 7;
            end else if (m_st == 7) begin
                if (close_ack) begin
                    m_done = 1;
                    if (se) begin ns = 0; m_halt = 1; end else ns = 1;
                end
            end else if (m_st == 6) begin
                if (cmd_stop) begin ns = 0; m_halt = 1; end
                else if (cmd_start) ns = 1;
            end
            m_pend = se && ns != 0;
            m_st = ns;
        end
    end

    task automatic chk(input string t, input int act_v, input int exp_v, input string what);
        n_chk++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act_v, exp_v, $time);
        end
    endtask

    // Compare every output with the model.
    task automatic compare();
        chk(tag, state_code, m_st, "state_code");
        chk("R2", int'(state_code == 3'b100 || state_code == 3'b101), 0, "reserved code");
        chk("R5", {fetch_req, rd_req, close_req},
            {m_st == 1, m_st == 3, m_st == 7}, "requests");
        chk(tag, {evt_tx_done, evt_buf_unavail, evt_stopped},
            {m_done, m_un, m_halt}, "events");
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic clear_in();
        cmd_start = 0; cmd_stop = 0; fetch_ack = 0; desc_own = 0;
        rd_done = 0; tx_end = 0; close_ack = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1;
        step();
        chk("R1", state_code, 0, "state after reset");

        // R11: stop in halted, start+stop together
        tag = "R11";
        cmd_stop = 1; step(); clear_in(); step();
        chk("R11", evt_stopped, 0, "no stop event in halt");
        cmd_start = 1; cmd_stop = 1; step(); clear_in(); step();
        chk("R11", state_code, 0, "start+stop stays halted");

        // R3: start, R12 stray handshakes in fetch
        tag = "R3";
        cmd_start = 1; step(); clear_in();
        chk("R3", state_code, 1, "start to fetch");
        tag = "R12";
        rd_done = 1; tx_end = 1; close_ack = 1; step(); clear_in(); step();
        chk("R12", state_code, 1, "stray handshakes in fetch");

        // R4 normal frame with R6 pulse
        tag = "R4";
        fetch_ack = 1; desc_own = 1; step(); clear_in();
        chk("R4", state_code, 3, "owned to read");
        tag = "R3";
        cmd_start = 1; fetch_ack = 1; close_ack = 1; step(); clear_in();
        chk("R3", state_code, 3, "start ignored in read");
        tag = "R4";
        rd_done = 1; step(); clear_in();
        chk("R4", state_code, 2, "read to wait");
        repeat (3) step();
        tx_end = 1; step(); clear_in();
        chk("R4", state_code, 7, "wait to close");
        tag = "R6";
        close_ack = 1; step(); clear_in();
        chk("R6", evt_tx_done, 1, "done pulse");
        chk("R6", state_code, 1, "back to fetch");
        step();
        chk("R6", evt_tx_done, 0, "done pulse one cycle");

        // R7 unowned descriptor, R12 in suspend, R8 resume
        tag = "R7";
        fetch_ack = 1; desc_own = 0; step(); clear_in();
        chk("R7", state_code, 6, "suspend");
        chk("R7", evt_buf_unavail, 1, "unavail pulse");
        tag = "R12";
        fetch_ack = 1; desc_own = 1; rd_done = 1; step(); clear_in();
        chk("R12", state_code, 6, "stray fetch_ack in suspend");
        tag = "R8";
        cmd_start = 1; step(); clear_in();
        chk("R8", state_code, 1, "resume fetch");

        // R9 stop during wait, frame finishes
        tag = "R9";
        fetch_ack = 1; desc_own = 1; step(); clear_in();
        rd_done = 1; step(); clear_in();
        cmd_stop = 1; step(); clear_in();
        chk("R9", state_code, 2, "stop defers in wait");
        tx_end = 1; step(); clear_in();
        chk("R9", state_code, 7, "closing despite stop");
        close_ack = 1; step(); clear_in();
        chk("R9", state_code, 0, "halted after close");
        chk("R9", evt_stopped & evt_tx_done, 1, "stop and done together");
        step();

        // R9 stop during read
        cmd_start = 1; step(); clear_in();
        fetch_ack = 1; desc_own = 1; step(); clear_in();
        cmd_stop = 1; step(); clear_in();
        rd_done = 1; step(); clear_in();
        tx_end = 1; step(); clear_in();
        close_ack = 1; step(); clear_in();
        chk("R9", state_code, 0, "stop in read halts after close");

        // R10 stop in suspend
        tag = "R10";
        cmd_start = 1; step(); clear_in();
        fetch_ack = 1; step(); clear_in();
        cmd_stop = 1; cmd_start = 1; step(); clear_in();
        chk("R10", state_code, 0, "stop in suspend");
        chk("R10", evt_stopped, 1, "stop pulse from suspend");

        // R10 stop pending at fetch, unowned
        cmd_start = 1; step(); clear_in();
        cmd_stop = 1; step(); clear_in();
        step();
        fetch_ack = 1; step(); clear_in();
        chk("R10", state_code, 0, "unowned with stop halts");
        chk("R10", evt_buf_unavail, 0, "no unavail with stop");
        repeat (3) step();

        // reset mid-frame
        tag = "R1";
        cmd_start = 1; step(); clear_in();
        fetch_ack = 1; desc_own = 1; step(); clear_in();
        rst_n = 0; step();
        chk("R1", state_code, 0, "reset mid-frame");
        rst_n = 1; step();
        finish_run();
    end
endmodule